// File: doc/BRIEF.md
# SAR conversion sequencer

This block is the digital control core of a 12-bit successive-approximation converter. A convert-start pulse arms it; on the high-to-low edge of that pulse it raises a busy flag, enables a gated clock and begins a bit-by-bit binary search. Each cycle it drives a trial word to an external feedback DAC. One cycle later it reads a single-bit comparator result and either keeps or drops the bit under trial. The MSB is tried first and the LSB last.

The result leaves the block as negative-true parallel data. The plain MSB line gives complementary straight binary for unipolar inputs and complementary offset binary for bipolar inputs. A separate line carries the inverted MSB, which turns the same word into complementary two's complement. A resolution select can end the search after 10 or 8 decisions instead of 12. A one-cycle done pulse marks the cycle in which busy falls, and the parallel data is already final in that cycle.

Top module: `sar_seq`

## Requirements
- R1: A conversion begins only on a high-to-low transition of `start_i` seen while idle. A rising edge, or `start_i` held high, leaves `busy_o` low.
- R2: Any activity on `start_i` while `busy_o` is high is ignored. It changes neither the result nor the conversion length.
- R3: `busy_o` is high for exactly N consecutive cycles and `gclk_en_o` for exactly N+1 (the start cycle plus N decision cycles), where N is the selected resolution.
- R4: In the first busy cycle, `trial_o` has only its MSB set and all lower bits at 0.
- R5: Each decision keeps the bit under trial when `cmp_i` is 1 (input at or above the trial level) and then sets the next lower bit for trial. With a full-resolution conversion, the final word equals the input code.
- R6: `res_sel_i` is captured at the start edge. 2'b00 and 2'b11 select 12 bits, 2'b01 selects 10 bits and 2'b10 selects 8 bits. In a short conversion the undecided lower bits stay 0 in the trial word, which is 1 on `data_no`.
- R7: Parallel outputs are final in the cycle in which `busy_o` falls, and they hold still while idle.
- R8: `data_no` is the bitwise complement of the decided word. `msb_inv_o` equals the inverse of `data_no[11]`.
- R9: While `rst_ni` is low, `busy_o`, `done_o`, `gclk_en_o`, `trial_o` and `msb_inv_o` are 0, and `data_no` is all ones.
- R10: `done_o` is a single-cycle pulse in the first cycle after `busy_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Convert-start pulse, acts on its falling edge |
| cmp_i | input | 1 | Comparator: 1 when the analog input is at or above the DAC level |
| res_sel_i | input | 2 | Resolution select (00/11: 12, 01: 10, 10: 8 bits) |
| trial_o | output | 12 | Trial word to the feedback DAC |
| data_no | output | 12 | Negative-true result word |
| msb_inv_o | output | 1 | Inverted MSB of the result, for two's-complement coding |
| busy_o | output | 1 | Conversion in progress |
| gclk_en_o | output | 1 | Gated clock enable |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The bench uses the default width of 12 with short-cycle drops of 2 and 4 bits. At these values every one of the 4096 input codes can be converted at full resolution, and the 10-bit and 8-bit modes can be swept densely. A comparator model in the bench closes the search loop, so each result and each conversion length is checked against the arithmetic truncation of the input code. Start glitches during a conversion and a reset during a conversion are also exercised.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    RES_FULL = 2'b00,
    RES_MID  = 2'b01,
    RES_LOW  = 2'b10,
    RES_ALT  = 2'b11
  } res_e;
endpackage

// File: rtl/sar_fall_det.sv
module sar_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/sar_step_ctrl.sv
module sar_step_ctrl
  import sar_seq_pkg::*;
#(
  parameter int W       = 12,
  parameter int SHORT_A = 2,
  parameter int SHORT_B = 4,
  parameter int IW      = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_fall_i,
  input  logic [1:0]    res_sel_i,
  output logic          busy_o,
  output logic          load_o,
  output logic [IW-1:0] idx_o,
  output logic          last_o,
  output logic          done_o,
  output logic          gclk_en_o
);
  logic          busy_q, done_q;
  logic [IW-1:0] idx_q, stop_idx;
  res_e          res_q;

  assign load_o = start_fall_i & ~busy_q;

  always_comb begin
    unique case (res_q)
      RES_MID: stop_idx = IW'(SHORT_A);
      RES_LOW: stop_idx = IW'(SHORT_B);
      default: stop_idx = '0;
    endcase
  end

  assign last_o = (idx_q == stop_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      res_q  <= RES_FULL;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        idx_q  <= IW'(W - 1);
        res_q  <= res_e'(res_sel_i);
      end else if (busy_q) begin
        if (last_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign idx_o     = idx_q;
  assign gclk_en_o = busy_q | load_o;

  assert_busy_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> busy_q);
  assert_idx_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> (idx_q == $past(idx_q) - 1'b1));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_on_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
endmodule

// File: rtl/sar_bits.sv
module sar_bits #(
  parameter int W  = 12,
  parameter int IW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          decide_i,
  input  logic          last_i,
  input  logic [IW-1:0] idx_i,
  input  logic          cmp_i,
  output logic [W-1:0]  sar_o
);
  logic [W-1:0] sar_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sar_q[b] <= 1'b0;
      end else if (load_i) begin
        sar_q[b] <= (b == W - 1);
      end else if (decide_i) begin
        if (idx_i == IW'(b))                          sar_q[b] <= cmp_i;
        else if (!last_i && (idx_i == IW'(b + 1)))    sar_q[b] <= 1'b1;
      end
    end
  end

  assign sar_o = sar_q;

  assert_msb_trial_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sar_q == {1'b1, {(W-1){1'b0}}}));
  assert_idle_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !decide_i) |=> $stable(sar_q));
  assert_one_new_trial_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decide_i |=> ($countones(sar_q & ~$past(sar_q)) <= 1));
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W       = 12,
  parameter int SHORT_A = 2,
  parameter int SHORT_B = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         cmp_i,
  input  logic [1:0]   res_sel_i,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] data_no,
  output logic         msb_inv_o,
  output logic         busy_o,
  output logic         gclk_en_o,
  output logic         done_o
);
  localparam int IW = $clog2(W + 1);

  logic          start_fall, load, last, busy;
  logic [IW-1:0] idx;
  logic [W-1:0]  sar;

  sar_fall_det u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (start_i),
    .fall_o (start_fall)
  );

  sar_step_ctrl #(.W(W), .SHORT_A(SHORT_A), .SHORT_B(SHORT_B), .IW(IW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_fall_i (start_fall),
    .res_sel_i    (res_sel_i),
    .busy_o       (busy),
    .load_o       (load),
    .idx_o        (idx),
    .last_o       (last),
    .done_o       (done_o),
    .gclk_en_o    (gclk_en_o)
  );

  sar_bits #(.W(W), .IW(IW)) u_bits (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .decide_i (busy),
    .last_i   (last),
    .idx_i    (idx),
    .cmp_i    (cmp_i),
    .sar_o    (sar)
  );

  assign trial_o   = sar;
  assign data_no   = ~sar;
  assign msb_inv_o = sar[W-1];
  assign busy_o    = busy;

  assert_busy_after_fall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(start_i) && !busy) |=> busy_o);
endmodule

// File: tb/sar_seq_test.sv
module sar_seq_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  res_sel = 2'b00;
  logic [11:0] vin = '0;
  logic [11:0] trial, data_n;
  logic        msb_inv, busy, gclk_en, done;
  logic        cmp;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  assign cmp = (vin >= trial);

  sar_seq uut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .cmp_i     (cmp),
    .res_sel_i (res_sel),
    .trial_o   (trial),
    .data_no   (data_n),
    .msb_inv_o (msb_inv),
    .busy_o    (busy),
    .gclk_en_o (gclk_en),
    .done_o    (done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [1:0] r);
    return (r == 2'b01) ? 10 : (r == 2'b10) ? 8 : 12;
  endfunction

  task automatic convert(input logic [1:0] r, input logic [11:0] v, input bit glitch);
    int n = nbits_of(r);
    logic [11:0] exp = v & (12'hFFF << (12 - n));
    int nb = 0, ng = 0, nd = 0, win = 0;
    bit seen_done = 0;
    @(negedge clk);
    vin = v; res_sel = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!seen_done && win < 40) begin
      #1;
      if (busy) nb++;
      if (gclk_en) ng++;
      if (done) begin
        nd++;
        seen_done = 1;
      end
      if (win == 1) check(trial == 12'h800, "R4 first trial", trial, 12'h800);
      if (!seen_done) begin
        @(negedge clk);
        win++;
        if (glitch && win == 3) start = 1'b1;
        if (glitch && win == 5) start = 1'b0;
        res_sel = ~r;
      end
    end
    check(nb == n, "R3 busy length", nb, n);
    check(ng == n + 1, "R3 gclk length", ng, n + 1);
    if (r == 2'b00 && !glitch) check(trial == v, "R5 result", trial, v);
    else if (glitch) check(trial == exp, "R2 result after glitch", trial, exp);
    else check(trial == exp, "R6 short result", trial, exp);
    check(data_n == ~exp, "R8 negative-true data", data_n, ~exp);
    check(msb_inv == exp[11], "R8 inverted msb", msb_inv, exp[11]);
    @(negedge clk); #1;
    check(!done && !busy, "R10 done single cycle", done, 0);
    vin = ~v;
    @(negedge clk); #1;
    check(data_n == ~exp, "R7 idle hold", data_n, ~exp);
  endtask

  initial begin
    #(8 * 190000);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done && !gclk_en, "R9 reset flags", {busy, done, gclk_en}, 0);
    check(data_n == 12'hFFF && trial == 0 && !msb_inv, "R9 reset data", data_n, 12'hFFF);
    rst_ni = 1'b1;
    // R1: rising edge and held level start nothing
    @(negedge clk); start = 1'b1;
    repeat (10) begin
      @(negedge clk); #1;
      check(!busy && !gclk_en, "R1 no start while high", busy, 0);
    end
    start = 1'b0;
    @(negedge clk); #1;
    check(busy, "R1 start on fall", busy, 1);
    repeat (16) @(negedge clk);

    for (int v = 0; v < 4096; v++) convert(2'b00, 12'(v), (v % 64) == 5);
    for (int v = 0; v < 4096; v += 5) convert(2'b01, 12'(v), (v % 160) == 0);
    for (int v = 0; v < 4096; v += 3) convert(2'b10, 12'(v), 1'b0);
    for (int v = 7; v < 4096; v += 97) convert(2'b11, 12'(v), 1'b0);

    // R9: reset during a conversion
    @(negedge clk); vin = 12'h5A5; res_sel = 2'b00; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(!busy && !gclk_en && data_n == 12'hFFF, "R9 reset mid conversion", data_n, 12'hFFF);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); #1;
    check(!busy, "R9 stays idle after reset", busy, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule